// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block handles the state side of taking a trap in a core with user, privileged and hyperprivileged levels. When it receives a one-cycle trap request with a 9-bit trap type and an entry flavour, it raises the trap level. It then writes a trap-stack entry at the new level, which holds a packed copy of the pre-trap control state, the masked PC and NPC, the trap type and the pre-trap hyper-state. In the same clock edge it rewrites the live control registers: trap level, global level, window pointer, processor state and hyper-state. A power-on request, or the synchronous reset, puts the block into the power-on state.

A load port writes the live registers directly. This is the path by which restored or software-written values arrive. A read port returns any trap-stack entry, selected by level. The handler address, instruction fetch and trap return are handled elsewhere.

Processor-state bits used throughout: IE=0, PRIV=1, AM=2, PEF=3, TLE=4, CLE=5, with bits 12:6 as other mode bits. Hyper-state bits: RED=0, HPRIV=1, IBE=2, TLZ=3. Entry flavour `entry_kind`: 0 = to privileged, 1 = to hyperprivileged, 2 or 3 = reset/error-state entry.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset or `por_req`, the outputs are tl=6, gl=3, cwp=0, pstate=0x00A (PEF and PRIV only), hpstate=0x3 (RED and HPRIV only), tick_npt=1 and done=0. A `por_req` also writes trap type 0x001 into the stack entry at level 6.
- R2: A `trap_req` raises tl by one, holding at 6 if tl is already 6. `done` is 1 in exactly the cycle after the strobe, and the updated registers are visible in that same cycle.
- R3: The stack entry at the new level holds the trap type and the pre-trap hpstate. It also holds a 43-bit saved word packed as follows: gl at 42:40, condition codes at 39:32, ASI at 31:24, pstate at 20:8, cwp at 4:0, and zero elsewhere.
- R4: The saved PC and NPC keep only bits 31:0, with the upper half zero, when the pre-trap pstate AM bit is 1. Otherwise all 64 bits are kept.
- R5: The new gl is min(gl+1, 2) for privileged entry and min(gl+1, 3) for hyperprivileged or reset/error-state entry.
- R6: cwp changes by trap type. Type 0x024 adds 1. Types 0x080–0x0BF add cansave+2. Types 0x0C0–0x0FF subtract 1. Every other type leaves it unchanged. Results wrap modulo 8.
- R7: Privileged entry sets PEF and PRIV, clears AM and IE, copies TLE into CLE, keeps the other pstate bits and leaves hpstate unchanged.
- R8: Hyperprivileged entry sets PEF and clears AM, IE and CLE, keeping PRIV and the other pstate bits. It also sets HPRIV, clears RED and IBE, and keeps TLZ.
- R9: Reset/error-state entry clears pstate except for the old PRIV bit, sets PEF, and sets hpstate to RED|HPRIV with IBE and TLZ cleared.
- R10: Priority is `por_req` over `trap_req` over `ld_en`. A load writes tl, gl, cwp, pstate, hpstate and tick_npt. With no request pending, all live state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset to power-on state |
| trap_req | input | 1 | One-cycle trap entry strobe |
| entry_kind | input | 2 | Entry flavour (0 priv, 1 hyper, 2/3 reset-error) |
| trap_type | input | 9 | Incoming trap type |
| por_req | input | 1 | Power-on reset request |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_pc | input | 64 | PC of the trapping instruction |
| cur_npc | input | 64 | Next PC |
| cansave | input | 3 | Free-window count used by spill-range types |
| ld_en | input | 1 | Load live registers |
| ld_tl | input | 3 | Trap level to load |
| ld_gl | input | 2 | Global level to load |
| ld_cwp | input | 3 | Window pointer to load |
| ld_pstate | input | 13 | Processor state to load |
| ld_hpstate | input | 4 | Hyper-state to load |
| ld_tick_npt | input | 1 | Tick-protect flag to load |
| rd_lvl | input | 3 | Trap-stack level to read |
| tl | output | 3 | Live trap level |
| gl | output | 2 | Live global level |
| cwp | output | 3 | Live window pointer |
| pstate | output | 13 | Live processor state |
| hpstate | output | 4 | Live hyper-state |
| tick_npt | output | 1 | Tick top bit (user reads blocked) |
| done | output | 1 | Trap entry complete pulse |
| rd_tstate | output | 43 | Saved state word at rd_lvl |
| rd_tpc | output | 64 | Saved PC at rd_lvl |
| rd_tnpc | output | 64 | Saved NPC at rd_lvl |
| rd_tt | output | 9 | Saved trap type at rd_lvl |
| rd_htstate | output | 4 | Saved hyper-state at rd_lvl |

## Verification
The assertions check the following on every cycle: the done pulse and its single-cycle width, the trap-level step with saturation, the global-level ceiling for privileged entry, the forced hyper-state bits of the hyperprivileged and reset/error flavours, the cleared AM/IE and set PEF after any entry, the power-on state, and hold behaviour when idle. The bench scenarios alone can show the exact packing of the saved state word, the PC masking, the window-pointer arithmetic across the type ranges and their wrap, the per-flavour rewriting of pstate, and which entries a trap or a power-on request writes.

// File: rtl/tes_pkg.sv
// Shared constants and types for the trap entry state save unit.
// Assumes a 13-bit processor state, 4-bit hyper-state and 43-bit saved word.
package tes_pkg;
    localparam int PS_W  = 13;
    localparam int HS_W  = 4;
    localparam int TS_W  = 43;
    localparam int TT_W  = 9;
    localparam int XW    = 64;

    localparam int PS_IE   = 0;
    localparam int PS_PRIV = 1;
    localparam int PS_AM   = 2;
    localparam int PS_PEF  = 3;
    localparam int PS_TLE  = 4;
    localparam int PS_CLE  = 5;

    localparam int HS_RED   = 0;
    localparam int HS_HPRIV = 1;
    localparam int HS_IBE   = 2;
    localparam int HS_TLZ   = 3;

    localparam logic [TT_W-1:0] POR_TT = 9'h001;

    typedef enum logic [1:0] {
        ENT_PRIV  = 2'b00,
        ENT_HYP   = 2'b01,
        ENT_ERR   = 2'b10,
        ENT_ERR_B = 2'b11
    } entry_kind_e;

    typedef struct packed {
        logic [TS_W-1:0] tstate;
        logic [XW-1:0]   tpc;
        logic [XW-1:0]   tnpc;
        logic [TT_W-1:0] tt;
        logic [HS_W-1:0] htstate;
    } stack_ent_t;
endpackage

// File: rtl/tes_cwp_step.sv
// Window pointer adjustment on trap entry.
// Computes the new window pointer from the trap type range; assumes NWIN >= 2.
module tes_cwp_step #(
    parameter int NWIN = 8,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic [CW-1:0] cwp_in,
    input  logic [CW-1:0] cansave,
    input  logic [8:0]    trap_type,
    output logic [CW-1:0] cwp_out
);
    localparam int SW = CW + 2;
    localparam logic [SW-1:0] NW_V = SW'(NWIN);

    logic [SW-1:0] sum;

    // Select the offset by trap type range and wrap modulo the window count.
    always_comb begin
        sum = SW'(cwp_in);
        if (trap_type == 9'h024)
            sum = SW'(cwp_in) + SW'(1);
        else if (trap_type >= 9'h080 && trap_type <= 9'h0BF)
            sum = SW'(cwp_in) + SW'(cansave) + SW'(2);
        else if (trap_type >= 9'h0C0 && trap_type <= 9'h0FF)
            sum = SW'(cwp_in) + NW_V - SW'(1);
        cwp_out = CW'(sum % NW_V);
    end
endmodule

// File: rtl/tes_ctl_next.sv
// Next processor state, hyper-state and global level for each entry flavour.
// Purely combinational; assumes MAX_PGL <= MAX_GL.
module tes_ctl_next
    import tes_pkg::*;
#(
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2,
    localparam int GLW    = $clog2(MAX_GL + 1)
) (
    input  entry_kind_e       kind,
    input  logic [PS_W-1:0]   ps_in,
    input  logic [HS_W-1:0]   hs_in,
    input  logic [GLW-1:0]    gl_in,
    output logic [PS_W-1:0]   ps_out,
    output logic [HS_W-1:0]   hs_out,
    output logic [GLW-1:0]    gl_out
);
    logic [GLW:0] lim;
    logic [GLW:0] inc;

    // Rewrite control bits according to the target mode.
    always_comb begin
        ps_out = ps_in;
        hs_out = hs_in;
        lim    = (GLW+1)'(MAX_GL);
        unique case (kind)
            ENT_PRIV: begin
                ps_out[PS_PEF]  = 1'b1;
                ps_out[PS_AM]   = 1'b0;
                ps_out[PS_IE]   = 1'b0;
                ps_out[PS_PRIV] = 1'b1;
                ps_out[PS_CLE]  = ps_in[PS_TLE];
                lim             = (GLW+1)'(MAX_PGL);
            end
            ENT_HYP: begin
                ps_out[PS_PEF]   = 1'b1;
                ps_out[PS_AM]    = 1'b0;
                ps_out[PS_IE]    = 1'b0;
                ps_out[PS_CLE]   = 1'b0;
                hs_out[HS_HPRIV] = 1'b1;
                hs_out[HS_RED]   = 1'b0;
                hs_out[HS_IBE]   = 1'b0;
            end
            default: begin
                ps_out           = '0;
                ps_out[PS_PRIV]  = ps_in[PS_PRIV];
                ps_out[PS_PEF]   = 1'b1;
                hs_out[HS_RED]   = 1'b1;
                hs_out[HS_HPRIV] = 1'b1;
                hs_out[HS_IBE]   = 1'b0;
                hs_out[HS_TLZ]   = 1'b0;
            end
        endcase
    end

    // Saturating global level increment.
    always_comb begin
        inc    = {1'b0, gl_in} + (GLW+1)'(1);
        gl_out = (inc > lim) ? GLW'(lim) : GLW'(inc);
    end
endmodule

// File: rtl/tes_stack.sv
// Per-level trap stack: one write port, one combinational read port.
// Entry 0 is never written; reads beyond MAX_TL return zero.
module tes_stack
    import tes_pkg::*;
#(
    parameter int MAX_TL = 6,
    localparam int TLW   = $clog2(MAX_TL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TLW-1:0]   wr_lvl,
    input  stack_ent_t       wr_ent,
    input  logic [TLW-1:0]   rd_lvl,
    output stack_ent_t       rd_ent
);
    stack_ent_t mem [MAX_TL+1];

    // Store an entry at the addressed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= MAX_TL; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i <= MAX_TL; i++)
                if (wr_lvl == TLW'(i)) mem[i] <= wr_ent;
        end
    end

    // Select the entry for the read level.
    always_comb begin
        rd_ent = '0;
        for (int i = 0; i <= MAX_TL; i++)
            if (rd_lvl == TLW'(i)) rd_ent = mem[i];
    end
endmodule

// File: rtl/trap_entry_unit.sv
// Trap entry state save unit: on a trap strobe, pushes the pre-trap control
// state to the trap stack at the raised level and rewrites live control
// registers. Assumes trap_req is a single-cycle strobe; por_req wins over it.
module trap_entry_unit
    import tes_pkg::*;
#(
    parameter int NWIN    = 8,
    parameter int MAX_TL  = 6,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2,
    localparam int TLW    = $clog2(MAX_TL + 1),
    localparam int GLW    = $clog2(MAX_GL + 1),
    localparam int CW     = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [1:0]       entry_kind,
    input  logic [8:0]       trap_type,
    input  logic             por_req,
    input  logic [7:0]       cur_ccr,
    input  logic [7:0]       cur_asi,
    input  logic [63:0]      cur_pc,
    input  logic [63:0]      cur_npc,
    input  logic [CW-1:0]    cansave,
    input  logic             ld_en,
    input  logic [TLW-1:0]   ld_tl,
    input  logic [GLW-1:0]   ld_gl,
    input  logic [CW-1:0]    ld_cwp,
    input  logic [12:0]      ld_pstate,
    input  logic [3:0]       ld_hpstate,
    input  logic             ld_tick_npt,
    input  logic [TLW-1:0]   rd_lvl,
    output logic [TLW-1:0]   tl,
    output logic [GLW-1:0]   gl,
    output logic [CW-1:0]    cwp,
    output logic [12:0]      pstate,
    output logic [3:0]       hpstate,
    output logic             tick_npt,
    output logic             done,
    output logic [42:0]      rd_tstate,
    output logic [63:0]      rd_tpc,
    output logic [63:0]      rd_tnpc,
    output logic [8:0]       rd_tt,
    output logic [3:0]       rd_htstate
);
    localparam logic [PS_W-1:0] POR_PS = PS_W'((1 << PS_PEF) | (1 << PS_PRIV));
    localparam logic [HS_W-1:0] POR_HS = HS_W'((1 << HS_RED) | (1 << HS_HPRIV));

    logic [TLW-1:0]  new_tl;
    logic [CW-1:0]   nxt_cwp;
    logic [PS_W-1:0] nxt_ps;
    logic [HS_W-1:0] nxt_hs;
    logic [GLW-1:0]  nxt_gl;
    logic [XW-1:0]   pc_mask;
    stack_ent_t      wr_ent;
    stack_ent_t      rd_ent;
    logic            take_trap;

    assign take_trap = trap_req && !por_req;

    tes_cwp_step #(.NWIN(NWIN)) u_cwp (
        .cwp_in   (cwp),
        .cansave  (cansave),
        .trap_type(trap_type),
        .cwp_out  (nxt_cwp)
    );

    tes_ctl_next #(.MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL)) u_ctl (
        .kind  (entry_kind_e'(entry_kind)),
        .ps_in (pstate),
        .hs_in (hpstate),
        .gl_in (gl),
        .ps_out(nxt_ps),
        .hs_out(nxt_hs),
        .gl_out(nxt_gl)
    );

    // Raised trap level, held at the maximum.
    always_comb begin
        new_tl  = (tl == TLW'(MAX_TL)) ? TLW'(MAX_TL) : tl + TLW'(1);
        pc_mask = pstate[PS_AM] ? {32'h0, 32'hFFFF_FFFF} : '1;
    end

    // Build the stack entry from the pre-trap state.
    always_comb begin
        wr_ent                = '0;
        wr_ent.tstate[42:40]  = 3'(gl);
        wr_ent.tstate[39:32]  = cur_ccr;
        wr_ent.tstate[31:24]  = cur_asi;
        wr_ent.tstate[20:8]   = pstate;
        wr_ent.tstate[4:0]    = 5'(cwp);
        wr_ent.tpc            = cur_pc & pc_mask;
        wr_ent.tnpc           = cur_npc & pc_mask;
        wr_ent.tt             = por_req ? POR_TT : trap_type;
        wr_ent.htstate        = hpstate;
    end

    tes_stack #(.MAX_TL(MAX_TL)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (por_req || trap_req),
        .wr_lvl(por_req ? TLW'(MAX_TL) : new_tl),
        .wr_ent(wr_ent),
        .rd_lvl(rd_lvl),
        .rd_ent(rd_ent)
    );

    // Live control registers: power-on, trap entry, or direct load.
    always_ff @(posedge clk) begin
        if (!rst_n || por_req) begin
            tl       <= TLW'(MAX_TL);
            gl       <= GLW'(MAX_GL);
            cwp      <= '0;
            pstate   <= POR_PS;
            hpstate  <= POR_HS;
            tick_npt <= 1'b1;
        end else if (trap_req) begin
            tl      <= new_tl;
            gl      <= nxt_gl;
            cwp     <= nxt_cwp;
            pstate  <= nxt_ps;
            hpstate <= nxt_hs;
        end else if (ld_en) begin
            tl       <= ld_tl;
            gl       <= ld_gl;
            cwp      <= ld_cwp;
            pstate   <= ld_pstate;
            hpstate  <= ld_hpstate;
            tick_npt <= ld_tick_npt;
        end
    end

    // Completion pulse one cycle after an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= take_trap;
    end

    assign rd_tstate  = rd_ent.tstate;
    assign rd_tpc     = rd_ent.tpc;
    assign rd_tnpc    = rd_ent.tnpc;
    assign rd_tt      = rd_ent.tt;
    assign rd_htstate = rd_ent.htstate;
endmodule

// File: rtl/tes_checker.sv
// Property checker for trap_entry_unit, attached by bind below.
// Observes top-level ports only.
module tes_checker #(
    parameter int MAX_TL  = 6,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2,
    parameter int TLW     = 3,
    parameter int GLW     = 2,
    parameter int CW      = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           trap_req,
    input logic [1:0]     entry_kind,
    input logic           por_req,
    input logic           ld_en,
    input logic [TLW-1:0] tl,
    input logic [GLW-1:0] gl,
    input logic [CW-1:0]  cwp,
    input logic [12:0]    pstate,
    input logic [3:0]     hpstate,
    input logic           tick_npt,
    input logic           done
);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !por_req) |=> done);

    assert_done_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && !por_req) |=> !done);

    assert_tl_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !por_req) |=>
        tl == (($past(tl) == TLW'(MAX_TL)) ? TLW'(MAX_TL) : $past(tl) + TLW'(1)));

    assert_gl_priv_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !por_req && entry_kind == 2'b00) |=>
        gl == (($past(gl) >= GLW'(MAX_PGL)) ? GLW'(MAX_PGL) : $past(gl) + GLW'(1)));

    assert_entry_ps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !por_req) |=> pstate[3] && !pstate[2] && !pstate[0]);

    assert_hyper_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !por_req && entry_kind == 2'b01) |=>
        hpstate[1] && !hpstate[0] && !hpstate[2]);

    assert_err_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !por_req && entry_kind[1]) |=> hpstate == 4'h3);

    assert_por_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> tl == TLW'(MAX_TL) && gl == GLW'(MAX_GL) && tick_npt
                    && pstate == 13'h000A && hpstate == 4'h3 && !done);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !por_req && !ld_en) |=>
        $stable(tl) && $stable(gl) && $stable(cwp) && $stable(pstate)
        && $stable(hpstate) && $stable(tick_npt));
endmodule

bind trap_entry_unit tes_checker #(
    .MAX_TL (MAX_TL),
    .MAX_GL (MAX_GL),
    .MAX_PGL(MAX_PGL),
    .TLW    (TLW),
    .GLW    (GLW),
    .CW     (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req),
    .entry_kind(entry_kind),
    .por_req   (por_req),
    .ld_en     (ld_en),
    .tl        (tl),
    .gl        (gl),
    .cwp       (cwp),
    .pstate    (pstate),
    .hpstate   (hpstate),
    .tick_npt  (tick_npt),
    .done      (done)
);

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
// Bench for trap_entry_unit: vector table walk, then directed cases.
module sim_trap_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [1:0]  entry_kind = '0;
    logic [8:0]  trap_type = '0;
    logic        por_req = 1'b0;
    logic [7:0]  cur_ccr = '0;
    logic [7:0]  cur_asi = '0;
    logic [63:0] cur_pc = '0;
    logic [63:0] cur_npc = '0;
    logic [2:0]  cansave = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_tl = '0;
    logic [1:0]  ld_gl = '0;
    logic [2:0]  ld_cwp = '0;
    logic [12:0] ld_pstate = '0;
    logic [3:0]  ld_hpstate = '0;
    logic        ld_tick_npt = 1'b0;
    logic [2:0]  rd_lvl = '0;
    logic [2:0]  tl;
    logic [1:0]  gl;
    logic [2:0]  cwp;
    logic [12:0] pstate;
    logic [3:0]  hpstate;
    logic        tick_npt;
    logic        done;
    logic [42:0] rd_tstate;
    logic [63:0] rd_tpc;
    logic [63:0] rd_tnpc;
    logic [8:0]  rd_tt;
    logic [3:0]  rd_htstate;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    trap_entry_unit u0 (.*);

    typedef struct packed {
        logic [1:0]  kind;
        logic [8:0]  tt;
        logic [2:0]  tl0;
        logic [1:0]  gl0;
        logic [2:0]  cwp0;
        logic [2:0]  cans;
        logic [12:0] ps0;
        logic [3:0]  hs0;
        logic [2:0]  etl;
        logic [1:0]  egl;
        logic [2:0]  ecwp;
        logic [12:0] eps;
        logic [3:0]  ehs;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 9'h024, 3'd0, 2'd0, 3'd7, 3'd0, 13'h0001, 4'h0, 3'd1, 2'd1, 3'd0, 13'h000A, 4'h0},
        '{2'd0, 9'h085, 3'd2, 2'd2, 3'd3, 3'd4, 13'h0015, 4'h0, 3'd3, 2'd2, 3'd1, 13'h003A, 4'h0},
        '{2'd1, 9'h0C3, 3'd1, 2'd2, 3'd0, 3'd0, 13'h1FE2, 4'hD, 3'd2, 2'd3, 3'd7, 13'h1FCA, 4'hA},
        '{2'd2, 9'h010, 3'd4, 2'd3, 3'd5, 3'd2, 13'h1FFF, 4'h4, 3'd5, 2'd3, 3'd5, 13'h000A, 4'h3},
        '{2'd3, 9'h0E0, 3'd0, 2'd0, 3'd0, 3'd0, 13'h0001, 4'h8, 3'd1, 2'd1, 3'd7, 13'h0008, 4'h3},
        '{2'd0, 9'h100, 3'd6, 2'd1, 3'd2, 3'd1, 13'h0000, 4'h2, 3'd6, 2'd2, 3'd2, 13'h000A, 4'h2},
        '{2'd1, 9'h0BF, 3'd0, 2'd3, 3'd6, 3'd7, 13'h0004, 4'h0, 3'd1, 2'd3, 3'd7, 13'h0008, 4'h2}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] t, input logic [1:0] g, input logic [2:0] c,
                        input logic [12:0] p, input logic [3:0] h, input logic tk);
        @(negedge clk);
        ld_en = 1'b1; ld_tl = t; ld_gl = g; ld_cwp = c;
        ld_pstate = p; ld_hpstate = h; ld_tick_npt = tk;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 tl", 64'(tl), 64'd6);
        chk("R1 gl", 64'(gl), 64'd3);
        chk("R1 cwp", 64'(cwp), 64'd0);
        chk("R1 pstate", 64'(pstate), 64'h00A);
        chk("R1 hpstate", 64'(hpstate), 64'h3);
        chk("R1 tick_npt", 64'(tick_npt), 64'd1);
        chk("R1 done", 64'(done), 64'd0);

        // Vector walk: R2..R9
        for (int i = 0; i < NV; i++) begin
            logic [63:0] pc;
            logic [63:0] msk;
            logic [42:0] ets;
            string rq;
            vec_t v;
            v = VECS[i];
            rq = (v.kind == 2'd0) ? "R7" : (v.kind == 2'd1) ? "R8" : "R9";
            load(v.tl0, v.gl0, v.cwp0, v.ps0, v.hs0, 1'b0);
            pc = 64'hFEDC_BA98_7654_3210 + 64'(i * 16);
            trap_req = 1'b1; entry_kind = v.kind; trap_type = v.tt;
            cansave = v.cans; cur_ccr = 8'hC0 ^ 8'(i); cur_asi = 8'h40 + 8'(i);
            cur_pc = pc; cur_npc = pc + 64'd4;
            @(negedge clk);
            trap_req = 1'b0;
            chk("R2 done", 64'(done), 64'd1);
            chk("R2 tl", 64'(tl), 64'(v.etl));
            chk("R5 gl", 64'(gl), 64'(v.egl));
            chk("R6 cwp", 64'(cwp), 64'(v.ecwp));
            chk({rq, " pstate"}, 64'(pstate), 64'(v.eps));
            chk({rq, " hpstate"}, 64'(hpstate), 64'(v.ehs));
            rd_lvl = v.etl;
            #1;
            ets = '0;
            ets[42:40] = {1'b0, v.gl0};
            ets[39:32] = 8'hC0 ^ 8'(i);
            ets[31:24] = 8'h40 + 8'(i);
            ets[20:8]  = v.ps0;
            ets[4:0]   = {2'b00, v.cwp0};
            msk = v.ps0[2] ? 64'h0000_0000_FFFF_FFFF : '1;
            chk("R3 tstate", 64'(rd_tstate), 64'(ets));
            chk("R3 tt", 64'(rd_tt), 64'(v.tt));
            chk("R3 htstate", 64'(rd_htstate), 64'(v.hs0));
            chk("R4 tpc", rd_tpc, pc & msk);
            chk("R4 tnpc", rd_tnpc, (pc + 64'd4) & msk);
            @(negedge clk);
            chk("R2 done width", 64'(done), 64'd0);
        end

        // R10: load without trap, then hold while idle
        load(3'd2, 2'd1, 3'd4, 13'h0155, 4'h6, 1'b0);
        chk("R10 ld tl", 64'(tl), 64'd2);
        chk("R10 ld pstate", 64'(pstate), 64'h155);
        chk("R10 ld tick", 64'(tick_npt), 64'd0);
        repeat (3) @(negedge clk);
        chk("R10 hold cwp", 64'(cwp), 64'd4);
        chk("R10 hold hpstate", 64'(hpstate), 64'h6);

        // R10: trap wins over load
        ld_en = 1'b1; ld_tl = 3'd0; ld_gl = 2'd0; ld_cwp = 3'd0;
        ld_pstate = 13'h0; ld_hpstate = 4'h0; ld_tick_npt = 1'b1;
        trap_req = 1'b1; entry_kind = 2'd0; trap_type = 9'h050;
        @(negedge clk);
        trap_req = 1'b0; ld_en = 1'b0;
        chk("R10 trap over load tl", 64'(tl), 64'd3);
        chk("R10 trap over load tick", 64'(tick_npt), 64'd0);
        chk("R6 cwp unchanged type", 64'(cwp), 64'd4);

        // R1/R10: power-on wins over trap
        por_req = 1'b1; trap_req = 1'b1; entry_kind = 2'd1; trap_type = 9'h024;
        @(negedge clk);
        por_req = 1'b0; trap_req = 1'b0;
        chk("R1 por tl", 64'(tl), 64'd6);
        chk("R1 por gl", 64'(gl), 64'd3);
        chk("R1 por cwp", 64'(cwp), 64'd0);
        chk("R1 por pstate", 64'(pstate), 64'h00A);
        chk("R1 por hpstate", 64'(hpstate), 64'h3);
        chk("R1 por tick", 64'(tick_npt), 64'd1);
        chk("R10 por done", 64'(done), 64'd0);
        rd_lvl = 3'd6;
        #1;
        chk("R1 por tt", 64'(rd_tt), 64'h001);

        summary();
    end
endmodule